// File: doc/BRIEF.md
# Systematic-Form Syndrome Encryptor

This block turns an n-bit error-vector plaintext into an mt-bit ciphertext by multiplying it, over GF(2), with a public key matrix held in systematic form `[I | K]`. Only the non-identity part `K` is ever presented to the block. The identity part adds nothing but the low mt plaintext bits, so the accumulator simply starts from those bits. The (n − mt) columns of `K` are then streamed in, one per qualified transfer, and each is XORed into the accumulator when its matching plaintext bit is set.

Software-side logic first loads the plaintext into an internal register while the block is idle. It then pulses a start strobe and feeds key columns at whatever pace it likes, using a valid strobe. Every column takes the same path whether or not it is used, so the number of cycles does not depend on the plaintext. After the last column a done flag rises. The ciphertext stays constant until the next start. The field degree m, the error count t and the code length n are parameters; for example m = 13, t = 119, n = 6960 is a legal setting.

Top module: `sys_syndrome_enc`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `ct` is all zeros.
- R2: When `pt_load` is high in an idle cycle (busy low, start low), the internal plaintext register takes `pt_data`. While `busy` is high, `pt_load` is ignored and the run in progress keeps the plaintext it started with.
- R3: When `start` is high while idle, on the next cycle `busy` is 1, `done` is 0 and `ct` equals plaintext bits [mt−1:0].
- R4: The column on the j-th valid transfer of a run (j counted from 0) is XORed into `ct` exactly when plaintext bit mt+j is 1. Otherwise `ct` keeps its value.
- R5: A cycle with `col_valid` low during a run changes neither `ct` nor the column position, whatever is on `col_data`.
- R6: In the cycle after the (n−mt)-th valid transfer, `busy` is 0 and `done` is 1. This timing is the same for every plaintext. `busy` and `done` are never high together.
- R7: While idle, `ct` and `done` hold their values until the next start, and `col_valid` has no effect.
- R8: `start` asserted while `busy` is high is ignored.
- R9: If `start` and `pt_load` are both high in the same idle cycle, the run starts from the previously loaded plaintext and the load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pt_load | input | 1 | Load `pt_data` into the plaintext register (idle only) |
| pt_data | input | CODE_N | Plaintext error vector |
| start | input | 1 | Begin a run (idle only) |
| col_valid | input | 1 | `col_data` carries the next key column |
| col_data | input | FIELD_M*ERR_T | One column of the public key part K |
| busy | output | 1 | Run in progress |
| done | output | 1 | Ciphertext complete and held |
| ct | output | FIELD_M*ERR_T | Ciphertext accumulator |

## Verification
The bench targets the plaintext-bit-to-column pairing at both ends of K (bits mt and n−1). A design that is off by one there would fold in a neighbouring column or miss the last one. It inserts idle gaps with junk on the column bus, which catches a design that counts or accumulates without `col_valid`. It also tries loads and starts in the middle of a run, a simultaneous start and load, and column strobes after done. A block that let any of these through would corrupt the held ciphertext or restart early. Plaintexts with every K bit clear and every K bit set check that done arrives on the same cycle in both cases.

// File: rtl/enc_pkg.sv
package enc_pkg;
    typedef struct packed {
        logic busy;
        logic done;
    } run_flags_t;
endpackage

// File: rtl/enc_pt_store.sv
module enc_pt_store #(
    parameter int CODE_N = 20,
    parameter int HEAD_W = 12,
    parameter int CW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [CODE_N-1:0] pt_in,
    input  logic              busy,
    input  logic [CW-1:0]     col_idx,
    output logic              key_bit,
    output logic [HEAD_W-1:0] head
);
    localparam int IW = (CODE_N > 1) ? $clog2(CODE_N) : 1;

    logic [CODE_N-1:0] pt_d, pt_q;
    logic [IW-1:0]     bit_idx;

    always_comb begin
        pt_d = pt_q;
        if (load_en) pt_d = pt_in;
        bit_idx = IW'(HEAD_W) + IW'(col_idx);
        key_bit = pt_q[bit_idx];
        head    = pt_q[HEAD_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pt_q <= '0;
        else        pt_q <= pt_d;
    end

    // plaintext frozen for the whole run
    p_pt_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(pt_q));
endmodule

// File: rtl/enc_col_seq.sv
module enc_col_seq
    import enc_pkg::*;
#(
    parameter int KC = 8,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          col_valid,
    output logic          init,
    output logic          take,
    output logic [CW-1:0] col_idx,
    output logic          busy,
    output logic          done
);
    localparam logic [CW-1:0] LAST = CW'(KC - 1);

    typedef struct packed {
        run_flags_t    flg;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        init = start && !st_q.flg.busy;
        take = col_valid && st_q.flg.busy;
        if (init) begin
            st_d.flg.busy = 1'b1;
            st_d.flg.done = 1'b0;
            st_d.cnt      = '0;
        end else if (take) begin
            if (st_q.cnt == LAST) begin
                st_d.flg.busy = 1'b0;
                st_d.flg.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign col_idx = st_q.cnt;
    assign busy    = st_q.flg.busy;
    assign done    = st_q.flg.done;

    p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (col_idx <= LAST));
    p_gap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !col_valid |=> busy && $stable(col_idx));
    p_done_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && col_valid && col_idx == LAST |=> done && !busy);
    p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    p_restart_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !col_valid |=> busy && !done);
endmodule

// File: rtl/enc_xor_acc.sv
module enc_xor_acc #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init,
    input  logic [W-1:0] init_val,
    input  logic         take,
    input  logic         use_col,
    input  logic [W-1:0] col,
    output logic [W-1:0] acc
);
    logic [W-1:0] acc_d, acc_q;
    logic [W-1:0] gated;

    always_comb begin
        gated = col & {W{use_col}};
        acc_d = acc_q;
        if (init)      acc_d = init_val;
        else if (take) acc_d = acc_q ^ gated;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc = acc_q;

    p_skip_col_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !init && !(take && use_col) |=> $stable(acc_q));
endmodule

// File: rtl/sys_syndrome_enc.sv
module sys_syndrome_enc #(
    parameter int FIELD_M = 4,
    parameter int ERR_T   = 3,
    parameter int CODE_N  = 20
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pt_load,
    input  logic [CODE_N-1:0]          pt_data,
    input  logic                       start,
    input  logic                       col_valid,
    input  logic [FIELD_M*ERR_T-1:0]   col_data,
    output logic                       busy,
    output logic                       done,
    output logic [FIELD_M*ERR_T-1:0]   ct
);
    localparam int MT = FIELD_M * ERR_T;
    localparam int KC = CODE_N - MT;
    localparam int CW = (KC > 1) ? $clog2(KC) : 1;

    logic          init, take, key_bit, load_en;
    logic [CW-1:0] col_idx;
    logic [MT-1:0] head;

    assign load_en = pt_load && !busy && !start;

    enc_col_seq #(.KC(KC), .CW(CW)) i_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .col_valid(col_valid),
        .init(init), .take(take), .col_idx(col_idx), .busy(busy), .done(done)
    );

    enc_pt_store #(.CODE_N(CODE_N), .HEAD_W(MT), .CW(CW)) i_pt (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .pt_in(pt_data),
        .busy(busy), .col_idx(col_idx), .key_bit(key_bit), .head(head)
    );

    enc_xor_acc #(.W(MT)) i_acc (
        .clk(clk), .rst_n(rst_n), .init(init), .init_val(head),
        .take(take), .use_col(key_bit), .col(col_data), .acc(ct)
    );

    p_init_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy && !done && ct == $past(head));
    p_ct_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(ct) && $stable(done));
    p_joint_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start && pt_load && !busy |=> ct == $past(head));
endmodule

// File: tb/test_sys_syndrome_enc.sv
module test_sys_syndrome_enc;
    localparam int M  = 4;
    localparam int T  = 3;
    localparam int N  = 20;
    localparam int MT = M * T;
    localparam int KC = N - MT;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pt_load = 1'b0;
    logic [N-1:0]  pt_data = '0;
    logic          start = 1'b0;
    logic          col_valid = 1'b0;
    logic [MT-1:0] col_data = '0;
    logic          busy, done;
    logic [MT-1:0] ct;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sys_syndrome_enc #(.FIELD_M(M), .ERR_T(T), .CODE_N(N)) i_sys_syndrome_enc (
        .clk(clk), .rst_n(rst_n), .pt_load(pt_load), .pt_data(pt_data),
        .start(start), .col_valid(col_valid), .col_data(col_data),
        .busy(busy), .done(done), .ct(ct)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural reference, compared every cycle
    logic [N-1:0]  m_pt = '0;
    logic [MT-1:0] m_acc = '0;
    int            m_cnt = 0;
    bit            m_busy = 0, m_done = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pt <= '0; m_acc <= '0; m_cnt <= 0; m_busy <= 0; m_done <= 0;
        end else if (!m_busy) begin
            if (start) begin
                m_acc <= m_pt[MT-1:0]; m_cnt <= 0; m_busy <= 1; m_done <= 0;
            end else if (pt_load) begin
                m_pt <= pt_data;
            end
        end else if (col_valid) begin
            if (m_pt[MT + m_cnt]) m_acc <= m_acc ^ col_data;
            if (m_cnt == KC - 1) begin m_busy <= 0; m_done <= 1; end
            else m_cnt <= m_cnt + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R6 model busy", 64'(busy), 64'(m_busy));
            chk("R6 model done", 64'(done), 64'(m_done));
            chk("R4 model ct", 64'(ct), 64'(m_acc));
        end
    end

    task automatic load_pt(input logic [N-1:0] v);
        @(negedge clk); pt_load = 1'b1; pt_data = v;
        @(negedge clk); pt_load = 1'b0;
    endtask

    // one full run; expected ciphertext computed from the definition
    task automatic run_enc(input logic [N-1:0] pt, input bit gaps, input bit poke);
        logic [MT-1:0] exp;
        logic [MT-1:0] c;
        exp = pt[MT-1:0];
        load_pt(pt);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R3 busy after start", 64'(busy), 64'd1);
        chk("R3 done cleared", 64'(done), 64'd0);
        chk("R3 head copied", 64'(ct), 64'(pt[MT-1:0]));
        for (int j = 0; j < KC; j++) begin
            if (gaps) begin
                col_valid = 1'b0; col_data = MT'($urandom);
                @(negedge clk);
                chk("R5 gap keeps busy", 64'(busy), 64'd1);
            end
            if (poke && j == 2) begin
                pt_load = 1'b1; pt_data = ~pt; start = 1'b1; col_valid = 1'b0;
                @(negedge clk);
                pt_load = 1'b0; start = 1'b0;
                chk("R8 start ignored while busy", 64'(busy), 64'd1);
            end
            c = MT'($urandom);
            if (pt[MT + j]) exp = exp ^ c;
            col_valid = 1'b1; col_data = c;
            @(negedge clk);
            if (j < KC - 1) chk("R6 not done early", 64'(done), 64'd0);
        end
        col_valid = 1'b0; col_data = '0;
        chk("R6 done after last column", 64'(done), 64'd1);
        chk("R6 busy dropped", 64'(busy), 64'd0);
        chk(poke ? "R2 load ignored mid run" : "R4 final ciphertext", 64'(ct), 64'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy reset", 64'(busy), 64'd0);
        chk("R1 done reset", 64'(done), 64'd0);
        chk("R1 ct reset", 64'(ct), 64'd0);
        rst_n = 1'b1;

        run_enc(N'(20'h5A3C7), 1'b0, 1'b0);
        // K bits all clear: ciphertext is the head only (R4)
        run_enc({ {KC{1'b0}}, MT'(12'hB61) }, 1'b0, 1'b0);
        // K bits all set, with gaps (R5), same done timing (R6)
        run_enc({ {KC{1'b1}}, MT'(12'h0F0) }, 1'b1, 1'b0);
        // only first and last K bits (R4 boundaries)
        run_enc({ 1'b1, {(KC-2){1'b0}}, 1'b1, MT'(12'h3C3) }, 1'b0, 1'b0);
        // mid-run load and start attempts (R2, R8)
        run_enc(N'(20'hC35E9), 1'b1, 1'b1);

        // R7: strobes while idle leave ct and done alone
        begin
            logic [MT-1:0] held;
            held = ct;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk); col_valid = 1'b1; col_data = MT'($urandom);
            end
            @(negedge clk); col_valid = 1'b0;
            chk("R7 ct held", 64'(ct), 64'(held));
            chk("R7 done held", 64'(done), 64'd1);
        end

        // R9: start with simultaneous load uses previous plaintext
        load_pt(N'(20'h00ABC));
        @(negedge clk); start = 1'b1; pt_load = 1'b1; pt_data = N'(20'hFF123);
        @(negedge clk); start = 1'b0; pt_load = 1'b0;
        chk("R9 head from old plaintext", 64'(ct), 64'(12'hABC));
        for (int j = 0; j < KC; j++) begin
            col_valid = 1'b1; col_data = MT'($urandom);
            @(negedge clk);
        end
        col_valid = 1'b0;
        chk("R9 old plaintext K bits zero", 64'(ct), 64'(12'hABC));

        repeat (2) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule